// File: doc/BRIEF.md
# Converter Read Sequencer

This block is a host-side controller for a 12-bit analog-to-digital converter that sits on an 8-bit bus. A one-cycle request starts a full transaction. The sequencer first issues a conversion-start write. It then waits until the conversion is complete. Next it reads the result back as two bytes and rebuilds a right-aligned 12-bit value. It ends the transaction with a single-cycle done pulse.

The converter presents its result left-aligned. The first byte, read with the byte select low, holds the eight upper bits. The second byte, read with the byte select high, holds the four lower bits in its upper nibble, followed by a nibble of padding. The sequencer can detect completion in one of two ways:

- Polling mode: it watches the converter's busy status, with a timeout that guards against a status that never clears.
- Fixed-wait mode: it waits a programmed number of cycles that is long enough to cover a conversion.

Setup, strobe-hold and access lengths are runtime inputs, counted in clock cycles. The strobe that starts a conversion is always the active-high enable. Reads can be timed either on the enable or on the active-low select.

Top module: `adc_rd_seq`

## Requirements
- R1: A `req_i` pulse seen while `busy_o` is low starts a sequence, and `busy_o` is high from the next cycle until the sequence ends. A `req_i` seen while `busy_o` is high is dropped: it neither restarts nor lengthens the running sequence, and it yields no second done.
- R2: For a conversion start, `rdcv_o` (1 = read, 0 = convert) and `sel_n_o` are driven low with `ce_o` low for max(setup,1) cycles. Then `ce_o` is high for max(hold,1) cycles. `rdcv_o` is already low in the cycle before `ce_o` rises.
- R3: In fixed-wait mode (`poll_mode_i`=0), done rises exactly S+H+W+2·(S+A+c+H)+1 sampling cycles after `req_i` is driven. Here each of S, H, A and W is the max of its input and 1, and c is `cs_strobe_i`.
- R4: In polling mode, no read strobe is active while `stat_i` is high. The reads start once `stat_i` has been sampled low.
- R5: In polling mode, if `stat_i` stays high for max(timeout,1) wait cycles, then `err_o` sets, `busy_o` drops and no done is given. `err_o` stays set until the next request is accepted, which clears it.
- R6: There are two reads. The first has `byte_sel_o`=0 and the second has `byte_sel_o`=1. Each read strobe (`ce_o`=1, `sel_n_o`=0, `rdcv_o`=1) lasts max(access,1)+c cycles. When c=1, `ce_o` is raised during the read setup, and `sel_n_o` is the strobe.
- R7: `result_o` equals {first byte[7:0], second byte[7:4]}. Second-byte bits [3:0] have no effect on the result.
- R8: `done_o` is high for exactly one cycle per completed sequence. `result_o` keeps its value until the next completed sequence, including across a timed-out one.
- R9: While reset is held, the outputs are `ce_o`=0, `sel_n_o`=1, `rdcv_o`=1, `byte_sel_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0 and `result_o`=0.
- R10: A value of zero on a setup, hold, access, wait or timeout input acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start request pulse |
| poll_mode_i | input | 1 | 1 = poll status, 0 = fixed wait |
| cs_strobe_i | input | 1 | 1 = time reads on the select line |
| setup_cyc_i | input | CNT_W | Control setup length |
| hold_cyc_i | input | CNT_W | Strobe hold / release length |
| access_cyc_i | input | CNT_W | Read access length |
| wait_cyc_i | input | CNT_W | Fixed conversion wait |
| timeout_cyc_i | input | CNT_W | Polling timeout |
| stat_i | input | 1 | Converter busy status (synchronous) |
| data_i | input | DW | Converter data bus |
| ce_o | output | 1 | Active-high enable strobe |
| sel_n_o | output | 1 | Active-low select |
| rdcv_o | output | 1 | 1 = read, 0 = convert |
| byte_sel_o | output | 1 | Byte select (0 = upper byte) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Polling timeout flag |
| result_o | output | RW | Rebuilt right-aligned result |

## Verification
In fixed-wait mode, done is due at one exact cycle, given by the R3 formula. The bench counts falling edges from the edge where it drives the request and compares that count against the arithmetic formula. This is done for every combination in a sweep of setup, hold, access and strobe choice, which includes the zero settings.

A monitor checks the phases inside the sequence against the requested lengths at falling edges. It counts setup cycles up to the conversion strobe, strobe length and read-strobe length, and checks each count when the phase ends.

In polling mode, completion depends on the converter model. The bench therefore waits for done with a bound, and checks ordering instead of exact timing. The timeout path is due at S+H+T+1 sampling cycles and is checked there.

// File: rtl/adc_rd_seq_pkg.sv
// Package: shared types for the converter read sequencer.
package adc_rd_seq_pkg;

    // Sequencer phases, in the order a normal transaction walks them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CV_SETUP,
        ST_CV_STROBE,
        ST_CV_WAIT,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_RELEASE
    } seq_state_e;

endpackage

// File: rtl/seq_timer.sv
// Module: seq_timer
// Phase-length down-counter. Loading value N-1 makes the phase last N cycles.
// expired_o is high in the last cycle of the phase.
// Assumes the owner reloads it on every phase change.
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seq_join.sv
// Module: seq_join
// Rebuilds a right-aligned result from the two byte reads.
// The upper byte is held and the upper bits of the lower byte are kept; the result
// register updates only on commit. Assumes the capture strobes fire in the last
// access cycle of each read.
module seq_join #(
    parameter int DW = 8,
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_hi_i,
    input  logic          cap_lo_i,
    input  logic          commit_i,
    input  logic [DW-1:0] data_i,
    output logic [RW-1:0] result_o
);

    localparam int LOW_W = RW - DW;

    logic [DW-1:0]    hi_q;
    logic [LOW_W-1:0] lo_q;
    logic [RW-1:0]    res_q;

    // Hold the two captured pieces until they are committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi_i) hi_q <= data_i;
            if (cap_lo_i) lo_q <= data_i[DW-1 -: LOW_W];
        end
    end

    // Publish the result once per completed sequence, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (commit_i) begin
            res_q <= {hi_q, lo_q};
        end
    end

    assign result_o = res_q;

endmodule

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq (top)
// Host-side sequencer for one conversion and a two-byte readback.
// A request starts a convert strobe. The sequencer waits (by status poll or a fixed count),
// then does two reads and rebuilds the result.
// Assumes: stat_i is synchronous to clk, and the configuration inputs are static
// while busy_o is high.
module adc_rd_seq
    import adc_rd_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 8,
    parameter int RW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             poll_mode_i,
    input  logic             cs_strobe_i,
    input  logic [CNT_W-1:0] setup_cyc_i,
    input  logic [CNT_W-1:0] hold_cyc_i,
    input  logic [CNT_W-1:0] access_cyc_i,
    input  logic [CNT_W-1:0] wait_cyc_i,
    input  logic [CNT_W-1:0] timeout_cyc_i,
    input  logic             stat_i,
    input  logic [DW-1:0]    data_i,
    output logic             ce_o,
    output logic             sel_n_o,
    output logic             rdcv_o,
    output logic             byte_sel_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [RW-1:0]    result_o
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] ld_val;
    logic             tmr_load, tmr_exp;
    logic             second_q;
    logic             done_q, err_q;
    logic             timeout_hit, last_release;
    logic             cap_hi, cap_lo;

    // Converts a cycle count into a timer load value; a count of zero acts as one cycle.
    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    // Choose the next phase and the length to load for it.
    always_comb begin
        state_d = state_q;
        ld_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_i) begin
                state_d = ST_CV_SETUP;
                ld_val  = len_m1(setup_cyc_i);
            end
            ST_CV_SETUP: if (tmr_exp) begin
                state_d = ST_CV_STROBE;
                ld_val  = len_m1(hold_cyc_i);
            end
            ST_CV_STROBE: if (tmr_exp) begin
                state_d = ST_CV_WAIT;
                ld_val  = poll_mode_i ? len_m1(timeout_cyc_i) : len_m1(wait_cyc_i);
            end
            ST_CV_WAIT: begin
                if (poll_mode_i) begin
                    if (!stat_i) begin
                        state_d = ST_RD_SETUP;
                        ld_val  = len_m1(setup_cyc_i);
                    end else if (tmr_exp) begin
                        state_d = ST_IDLE;
                    end
                end else if (tmr_exp) begin
                    state_d = ST_RD_SETUP;
                    ld_val  = len_m1(setup_cyc_i);
                end
            end
            ST_RD_SETUP: if (tmr_exp) begin
                state_d = ST_RD_ACCESS;
                ld_val  = len_m1(access_cyc_i) + {{(CNT_W-1){1'b0}}, cs_strobe_i};
            end
            ST_RD_ACCESS: if (tmr_exp) begin
                state_d = ST_RD_RELEASE;
                ld_val  = len_m1(hold_cyc_i);
            end
            ST_RD_RELEASE: if (tmr_exp) begin
                state_d = second_q ? ST_IDLE : ST_RD_SETUP;
                ld_val  = len_m1(setup_cyc_i);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_load     = (state_d != state_q);
    assign timeout_hit  = (state_q == ST_CV_WAIT) && poll_mode_i && stat_i && tmr_exp;
    assign last_release = (state_q == ST_RD_RELEASE) && tmr_exp && second_q;
    assign cap_hi       = (state_q == ST_RD_ACCESS) && tmr_exp && !second_q;
    assign cap_lo       = (state_q == ST_RD_ACCESS) && tmr_exp && second_q;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tracks which of the two reads is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE)              second_q <= 1'b0;
        else if (state_q == ST_RD_RELEASE && tmr_exp)  second_q <= 1'b1;
    end

    // Done pulse and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= last_release;
            if (state_q == ST_IDLE && req_i) err_q <= 1'b0;
            else if (timeout_hit)            err_q <= 1'b1;
        end
    end

    // Bus control levels for each phase.
    always_comb begin
        ce_o       = 1'b0;
        sel_n_o    = 1'b1;
        rdcv_o     = 1'b1;
        byte_sel_o = 1'b0;
        unique case (state_q)
            ST_CV_SETUP: begin
                sel_n_o = 1'b0;
                rdcv_o  = 1'b0;
            end
            ST_CV_STROBE: begin
                ce_o    = 1'b1;
                sel_n_o = 1'b0;
                rdcv_o  = 1'b0;
            end
            ST_RD_SETUP: begin
                byte_sel_o = second_q;
                ce_o       = cs_strobe_i;
                sel_n_o    = cs_strobe_i;
            end
            ST_RD_ACCESS: begin
                byte_sel_o = second_q;
                ce_o       = 1'b1;
                sel_n_o    = 1'b0;
            end
            ST_RD_RELEASE: byte_sel_o = second_q;
            default: ;
        endcase
    end

    seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (ld_val),
        .expired_o  (tmr_exp)
    );

    seq_join #(.DW(DW), .RW(RW)) i_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_hi_i (cap_hi),
        .cap_lo_i (cap_lo),
        .commit_i (last_release),
        .data_i   (data_i),
        .result_o (result_o)
    );

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R1: an accepted request makes the block busy on the next cycle.
    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o);

    // R2: the conversion strobe is preceded by convert mode and select.
    p_cv_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && !sel_n_o && !rdcv_o) |-> ($past(!rdcv_o) && $past(!sel_n_o)));

    // R5: a timeout leaves the block idle.
    p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

    // R6: the byte select does not move while a read strobe is held.
    p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && !sel_n_o && rdcv_o && $past(ce_o && !sel_n_o && rdcv_o)) |-> $stable(byte_sel_o));

    // R8: done lasts a single cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/test_adc_rd_seq.sv
`timescale 1ns/1ps
module test_adc_rd_seq;
    localparam int CNT_W = 8;
    localparam int DW    = 8;
    localparam int RW    = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0, req = 1'b0, poll = 1'b0, csm = 1'b0;
    logic [CNT_W-1:0] s_cyc = '0, h_cyc = '0, a_cyc = '0, w_cyc = '0, t_cyc = '0;
    logic             stat;
    logic [DW-1:0]    data;
    logic             ce, sel_n, rdcv, bsel, busy, done, err;
    logic [RW-1:0]    result;

    int n_tests = 0, n_fail = 0;

    adc_rd_seq #(.CNT_W(CNT_W), .DW(DW), .RW(RW)) i_adc_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .poll_mode_i(poll), .cs_strobe_i(csm),
        .setup_cyc_i(s_cyc), .hold_cyc_i(h_cyc), .access_cyc_i(a_cyc),
        .wait_cyc_i(w_cyc), .timeout_cyc_i(t_cyc), .stat_i(stat), .data_i(data),
        .ce_o(ce), .sel_n_o(sel_n), .rdcv_o(rdcv), .byte_sel_o(bsel),
        .busy_o(busy), .done_o(done), .err_o(err), .result_o(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Converter model: starts on the convert strobe, stays busy conv_len edges.
    logic        cbusy = 1'b0;
    int          ccnt = 0, conv_len = 3;
    bit          stuck = 0;
    logic [11:0] cval = '0, next_val = '0;
    always @(posedge clk) begin
        if (!rst_n) cbusy <= 1'b0;
        else if (ce && !sel_n && !rdcv && !cbusy) begin
            cbusy <= 1'b1; ccnt <= conv_len; cval <= next_val;
        end else if (cbusy && !stuck) begin
            if (ccnt <= 1) cbusy <= 1'b0;
            ccnt <= ccnt - 1;
        end
    end
    assign stat = cbusy;
    // Second byte carries a nonzero low nibble to show it is ignored (R7).
    assign data = (ce && !sel_n && rdcv) ? (bsel ? {cval[3:0], 4'hA} : cval[11:4]) : 8'hEE;

    // Phase monitor at falling edges.
    int exp_s = 1, exp_h = 1, exp_a = 1, rd_idx = 0;
    int set_len = 0, stb_len = 0, rd_len = 0;
    bit p_cvs = 0, p_rda = 0, p_rdcv = 1, rd_bsel = 0, saw_busy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit cvs, rda, setup_now;
            cvs = ce && !sel_n && !rdcv;
            rda = ce && !sel_n && rdcv;
            setup_now = !ce && !sel_n && !rdcv;
            if (cvs && !p_cvs) check(!p_rdcv && set_len == exp_s, "R2 setup before strobe", set_len, exp_s);
            if (!cvs && p_cvs) check(stb_len == exp_h, "R2 strobe hold", stb_len, exp_h);
            if (!rda && p_rda) begin
                check(rd_len == exp_a, "R6 read strobe length", rd_len, exp_a);
                check(rd_bsel == rd_idx[0], "R6 byte order", int'(rd_bsel), rd_idx % 2);
                check(!saw_busy, "R4 read while converter busy", int'(saw_busy), 0);
                rd_idx++;
            end
            if (rda && !p_rda) saw_busy = stat;
            else if (rda)      saw_busy = saw_busy | stat;
            if (rda) rd_bsel = bsel;
            set_len = setup_now ? set_len + 1 : 0;
            stb_len = cvs ? stb_len + 1 : 0;
            rd_len  = rda ? rd_len + 1 : 0;
            p_cvs = cvs; p_rda = rda; p_rdcv = rdcv;
        end
    end

    function automatic int m1(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    // Runs one sequence; returns the sampling-cycle latency and the done count.
    task automatic run_seq(input int s, input int h, input int a, input int c, input int w,
                           input bit pm, input logic [11:0] v, input int cl, input bit mid,
                           output int lat, output int ndone);
        s_cyc = CNT_W'(s); h_cyc = CNT_W'(h); a_cyc = CNT_W'(a); w_cyc = CNT_W'(w);
        csm = c[0]; poll = pm; next_val = v; conv_len = cl;
        exp_s = m1(s); exp_h = m1(h); exp_a = m1(a) + c; rd_idx = 0;
        req = 1'b1; lat = 0; ndone = 0;
        do begin
            @(negedge clk);
            if (lat == 0) req = 1'b0;
            lat++;
            if (mid && lat == 3) begin
                check(busy == 1'b1, "R1 busy when second request arrives", int'(busy), 1);
                req = 1'b1;
            end
            if (mid && lat == 4) req = 1'b0;
        end while (!done && lat < 2000);
        if (done) ndone = 1;
        check(!busy, "R1 idle when done", int'(busy), 0);
        @(negedge clk);
        check(!done, "R8 done single pulse", int'(done), 0);
        for (int k = 0; k < 8; k++) begin
            if (done) ndone++;
            @(negedge clk);
        end
        check(!busy, "R1 no restart from dropped request", int'(busy), 0);
    endtask

    initial begin
        int lat, nd, idx, expl;
        logic [11:0] v, keep;
        repeat (3) @(negedge clk);
        check(ce == 0 && sel_n == 1 && rdcv == 1 && bsel == 0, "R9 reset bus levels",
              {ce, sel_n, rdcv, bsel}, 4'b0110);
        check(busy == 0 && done == 0 && err == 0 && result == 0, "R9 reset status",
              {busy, done, err, |result}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fixed-wait sweep with zero settings included (R3, R6, R7, R10).
        idx = 0;
        for (int s = 0; s < 3; s++)
            for (int h = 0; h < 3; h++)
                for (int a = 0; a < 3; a++)
                    for (int c = 0; c < 2; c++) begin
                        v = 12'((idx * 733 + 291) & 12'hFFF);
                        run_seq(s, h, a, c, 4, 1'b0, v, 3, 1'b0, lat, nd);
                        expl = m1(s) + m1(h) + 4 + 2 * (m1(s) + m1(a) + c + m1(h)) + 1;
                        check(lat == expl, "R3 fixed-wait latency (R10 zero as one)", lat, expl);
                        check(result == v, "R7 rebuilt result", result, v);
                        check(nd == 1, "R8 one done per sequence", nd, 1);
                        idx++;
                    end

        // Polling mode over conversion lengths (R4).
        t_cyc = 8'd40;
        for (int cl = 1; cl < 9; cl++) begin
            v = 12'((cl * 1111 + 7) & 12'hFFF);
            run_seq(1, 1, 1, cl % 2, 0, 1'b1, v, cl * 3, 1'b0, lat, nd);
            check(nd == 1 && !err, "R4 polled sequence completes", nd, 1);
            check(result == v, "R7 polled result", result, v);
        end

        // Second request during a running sequence is dropped (R1).
        v = 12'hF0F;
        run_seq(2, 1, 2, 0, 4, 1'b0, v, 3, 1'b1, lat, nd);
        expl = 2 + 1 + 4 + 2 * (2 + 2 + 0 + 1) + 1;
        check(lat == expl, "R1 latency unchanged by dropped request", lat, expl);
        check(nd == 1, "R1 single done", nd, 1);
        check(result == v, "R7 result after dropped request", result, v);

        // Timeout in polling mode (R5, R8 hold).
        keep = result;
        stuck = 1; t_cyc = 8'd20; poll = 1'b1; s_cyc = 8'd1; h_cyc = 8'd1; next_val = 12'h123;
        exp_s = 1; exp_h = 1;
        req = 1'b1; lat = 0; nd = 0;
        do begin
            @(negedge clk);
            if (lat == 0) req = 1'b0;
            lat++;
            if (done) nd++;
        end while (busy && lat < 500);
        check(lat == 1 + 1 + 20 + 1, "R5 timeout cycle", lat, 23);
        check(err == 1'b1, "R5 error flag set", int'(err), 1);
        check(nd == 0, "R5 no done on timeout", nd, 0);
        check(result == keep, "R8 result held over timeout", result, keep);
        stuck = 0;
        repeat (10) @(negedge clk);
        check(err == 1'b1, "R5 error flag persists", int'(err), 1);
        t_cyc = 8'd40; s_cyc = 8'd0; h_cyc = 8'd0; a_cyc = 8'd0; csm = 1'b1;
        exp_s = 1; exp_h = 1; exp_a = 2; rd_idx = 0; next_val = 12'h5C3; conv_len = 2;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(err == 1'b0, "R5 error cleared on accept", int'(err), 0);
        lat = 0;
        while (!done && lat < 500) begin @(negedge clk); lat++; end
        check(done == 1'b1, "R4 recovery sequence completes", int'(done), 1);
        @(negedge clk);
        check(result == 12'h5C3, "R7 recovery result", result, 12'h5C3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule